// File: doc/BRIEF.md
# Tunable Digital Downconverter and Requantizer

This block is the input end of one channel in a bank of tunable filters. A stream of 3-bit real samples is multiplied by a digital local oscillator. The oscillator comes from a free-running phase accumulator that steps by a programmable frequency word, and a 6-bit cosine / negative-sine table generated at elaboration time. The result is a complex (I/Q) channel centred on the chosen frequency. Each branch then passes through an unsigned gain with a fixed binary shift and saturation. It is finally requantized to a 2-bit or 4-bit code. A bypass mode skips the mixing and requantizes the scaled input directly on I.

Configuration comes in on pins and takes effect only when a load strobe is pulsed. The same strobe restarts the oscillator phase, so that several channels loaded together start coherent. The decimating filter that would normally sit between the mixer and the gain is treated as a pass-through.

Top module: `ddc_requant`

## Requirements
- R1: After reset, valid_o is low, i_o and q_o are 0, and the active configuration is: frequency word 0, gain 64, threshold 32, bypass off, 2-bit output.
- R2: Configuration pins are captured only in a cycle with cfg_load_i high. Changing them at any other time has no effect on the outputs.
- R3: The phase accumulator is cleared by cfg_load_i. The sample accepted in the first cycle after the load uses phase 0. The phase advances by the frequency word every clock, whether or not a sample is valid. The table index is the top 6 bits of the 32-bit phase.
- R4: A 3-bit input code c stands for the signed level 2c-7, so 000 is -7 and 111 is +7.
- R5: Table entry k holds round(31*cos(2*pi*k/64)) for the cosine, and round(-31*sin(2*pi*k/64)) for the negative sine.
- R6: When not bypassed, the I product is level*cos and the Q product is level*(-sin), both taken at the sample's phase index.
- R7: Each product is multiplied by the unsigned 8-bit gain and shifted right arithmetically by 6 (rounding toward minus infinity). It is then saturated to the range -128..127.
- R8: In 2-bit mode, with T the 7-bit threshold and x the saturated value, the code is 11 for x>=T, 10 for 0<=x<T, 01 for -T<=x<0, and 00 otherwise. The code sits in bits [1:0], and bits [3:2] are 0.
- R9: In 4-bit mode the output is the top 4 bits of the saturated 8-bit value, which is x>>>4 in two's complement.
- R10: In bypass mode the I product is level*31 and the Q product is 0, whatever the oscillator phase.
- R11: A sample accepted with valid_i at a clock edge appears on the outputs after the third edge counted from that one, with valid_o high. No output is flagged valid without a valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample qualifier |
| sample_i | input | 3 | Input sample code |
| cfg_load_i | input | 1 | Capture configuration and clear oscillator phase |
| cfg_freq_i | input | 32 | Phase increment per clock |
| cfg_gain_i | input | 8 | Unsigned gain, unity at 64 |
| cfg_thresh_i | input | 7 | Outer threshold for 2-bit requantization |
| cfg_bypass_i | input | 1 | Skip mixing; requantize scaled input on I |
| cfg_wide_i | input | 1 | Select 4-bit output instead of 2-bit |
| valid_o | output | 1 | Output sample qualifier |
| i_o | output | 4 | In-phase requantized code |
| q_o | output | 4 | Quadrature requantized code |

## Verification
A wrong phase accumulator or table value shows up as a wrong I or Q code on the first sample it touches. Any sample exactly three clocks old exposes it, so the bench steps the index one table entry per clock across a full period. A corrupted configuration register, or one captured without the strobe, changes the codes of every following sample. The bench drives random values on the configuration pins in every cycle without a load, so such a fault appears within one burst. Saturation, floor shifting and threshold faults show only at the extremes, which are driven on purpose with gains 0 and 255 and thresholds 0 and 127.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  typedef enum logic [1:0] {
    Q2_NEG_HI = 2'b00,
    Q2_NEG_LO = 2'b01,
    Q2_POS_LO = 2'b10,
    Q2_POS_HI = 2'b11
  } q2_code_e;

  // pi in Q30 fixed point
  localparam longint PI_Q30 = 64'sd3373259426;

  // round(amp * sin(2*pi*k / 2**aw)), Taylor series on the folded quarter wave
  function automatic int lut_sine(int k, int aw, int amp);
    int     quarter;
    int     kk;
    int     quad;
    int     j;
    longint x;
    longint term;
    longint acc;
    longint mag;
    quarter = 1 << (aw - 2);
    kk      = k % (4 * quarter);
    quad    = kk / quarter;
    j       = kk % quarter;
    if (quad == 1 || quad == 3) j = quarter - j;
    x    = (PI_Q30 * j) / (2 * quarter);
    term = x;
    acc  = x;
    for (int n = 1; n < 8; n++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -term / (2 * n * (2 * n + 1));
      acc  = acc + term;
    end
    mag = (longint'(amp) * acc + (64'sd1 << 29)) >>> 30;
    return (quad >= 2) ? -int'(mag) : int'(mag);
  endfunction

endpackage

// File: rtl/ddc_nco.sv
module ddc_nco #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 6,
  parameter int LUT_W   = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [PHASE_W-1:0]      freq_i,
  output logic signed [LUT_W-1:0] cos_o,
  output logic signed [LUT_W-1:0] nsin_o
);

  localparam int N   = 1 << LUT_AW;
  localparam int QTR = N / 4;
  localparam int AMP = (1 << (LUT_W - 1)) - 1;

  logic [PHASE_W-1:0]      acc_q;
  logic [LUT_AW-1:0]       idx;
  logic signed [LUT_W-1:0] cos_tab  [N];
  logic signed [LUT_W-1:0] nsin_tab [N];

  for (genvar k = 0; k < N; k++) begin : g_lut
    localparam int CV = ddc_pkg::lut_sine(k + QTR, LUT_AW, AMP);
    localparam int SV = -ddc_pkg::lut_sine(k, LUT_AW, AMP);
    assign cos_tab[k]  = CV[LUT_W-1:0];
    assign nsin_tab[k] = SV[LUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= '0;
    else             acc_q <= acc_q + freq_i;
  end

  assign idx    = acc_q[PHASE_W-1 -: LUT_AW];
  assign cos_o  = cos_tab[idx];
  assign nsin_o = nsin_tab[idx];

  a_r3_acc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> acc_q == '0);

  a_r3_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> acc_q == $past(acc_q) + $past(freq_i));

endmodule

// File: rtl/ddc_mix.sv
module ddc_mix #(
  parameter int IN_W   = 3,
  parameter int LUT_W  = 6,
  parameter int PROD_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [IN_W-1:0]          sample_i,
  input  logic signed [LUT_W-1:0]  cos_i,
  input  logic signed [LUT_W-1:0]  nsin_i,
  input  logic                     bypass_i,
  output logic signed [PROD_W-1:0] prod_i_o,
  output logic signed [PROD_W-1:0] prod_q_o
);

  localparam int AMP = (1 << (LUT_W - 1)) - 1;

  logic signed [IN_W:0]     lvl;
  logic signed [PROD_W-1:0] mul_i;
  logic signed [PROD_W-1:0] mul_q;

  // offset code to odd symmetric level: 2c - (2^IN_W - 1)
  assign lvl = {~sample_i[IN_W-1], sample_i[IN_W-2:0], 1'b1};

  always_comb begin
    if (bypass_i) begin
      mul_i = PROD_W'(lvl) * PROD_W'(AMP);
      mul_q = '0;
    end else begin
      mul_i = PROD_W'(lvl) * PROD_W'(cos_i);
      mul_q = PROD_W'(lvl) * PROD_W'(nsin_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_i_o <= '0;
      prod_q_o <= '0;
    end else begin
      prod_i_o <= mul_i;
      prod_q_o <= mul_q;
    end
  end

  a_r10_bypass_q_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> prod_q_o == '0);

endmodule

// File: rtl/ddc_scale.sv
module ddc_scale #(
  parameter int PROD_W = 10,
  parameter int GAIN_W = 8,
  parameter int SHIFT  = 6,
  parameter int SAT_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic [GAIN_W-1:0]        gain_i,
  output logic signed [SAT_W-1:0]  data_o
);

  localparam int MUL_W = PROD_W + GAIN_W + 1;
  localparam logic signed [MUL_W-1:0] MAXV = MUL_W'((1 << (SAT_W - 1)) - 1);
  localparam logic signed [MUL_W-1:0] MINV = MUL_W'(-(1 << (SAT_W - 1)));

  logic signed [MUL_W-1:0] mul;
  logic signed [MUL_W-1:0] shr;
  logic signed [SAT_W-1:0] sat;

  assign mul = MUL_W'(prod_i) * MUL_W'($signed({1'b0, gain_i}));
  assign shr = mul >>> SHIFT;

  always_comb begin
    if (shr > MAXV)      sat = MAXV[SAT_W-1:0];
    else if (shr < MINV) sat = MINV[SAT_W-1:0];
    else                 sat = shr[SAT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= sat;
  end

  a_r7_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (data_o < 0) == ($past(prod_i) < 0 && $past(gain_i) != '0));

endmodule

// File: rtl/ddc_quant.sv
module ddc_quant #(
  parameter int SAT_W = 8,
  parameter int OUT_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SAT_W-1:0] data_i,
  input  logic [SAT_W-2:0]        thr_i,
  input  logic                    wide_i,
  output logic [OUT_W-1:0]        code_o
);

  import ddc_pkg::*;

  logic signed [SAT_W-1:0] t_pos;
  logic signed [SAT_W-1:0] t_neg;
  q2_code_e                c2;
  logic [OUT_W-1:0]        nxt;

  assign t_pos = $signed({1'b0, thr_i});
  assign t_neg = -t_pos;

  always_comb begin
    if (data_i >= t_pos)      c2 = Q2_POS_HI;
    else if (data_i >= 0)     c2 = Q2_POS_LO;
    else if (data_i >= t_neg) c2 = Q2_NEG_LO;
    else                      c2 = Q2_NEG_HI;
  end

  assign nxt = wide_i ? data_i[SAT_W-1 -: OUT_W] : OUT_W'(c2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= '0;
    else         code_o <= nxt;
  end

  a_r8_top_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |=> code_o[OUT_W-1:2] == '0);

endmodule

// File: rtl/ddc_requant.sv
module ddc_requant #(
  parameter int PHASE_W = 32,
  parameter int IN_W    = 3,
  parameter int LUT_AW  = 6,
  parameter int LUT_W   = 6,
  parameter int GAIN_W  = 8,
  parameter int SHIFT   = 6,
  parameter int SAT_W   = 8,
  parameter int OUT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [IN_W-1:0]    sample_i,
  input  logic               cfg_load_i,
  input  logic [PHASE_W-1:0] cfg_freq_i,
  input  logic [GAIN_W-1:0]  cfg_gain_i,
  input  logic [SAT_W-2:0]   cfg_thresh_i,
  input  logic               cfg_bypass_i,
  input  logic               cfg_wide_i,
  output logic               valid_o,
  output logic [OUT_W-1:0]   i_o,
  output logic [OUT_W-1:0]   q_o
);

  localparam int PROD_W   = IN_W + 1 + LUT_W;
  localparam int STAGES   = 3;
  localparam int GAIN_RST = 1 << SHIFT;
  localparam int THR_RST  = 1 << (SAT_W - 3);

  logic [PHASE_W-1:0]      freq_q;
  logic [GAIN_W-1:0]       gain_q;
  logic [SAT_W-2:0]        thr_q;
  logic                    bypass_q;
  logic                    wide_q;
  logic [STAGES-1:0]       v_q;

  logic signed [LUT_W-1:0]  lo_cos;
  logic signed [LUT_W-1:0]  lo_nsin;
  logic signed [PROD_W-1:0] prod [2];
  logic signed [SAT_W-1:0]  scl  [2];
  logic [OUT_W-1:0]         code [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q   <= '0;
      gain_q   <= GAIN_W'(GAIN_RST);
      thr_q    <= (SAT_W-1)'(THR_RST);
      bypass_q <= 1'b0;
      wide_q   <= 1'b0;
    end else if (cfg_load_i) begin
      freq_q   <= cfg_freq_i;
      gain_q   <= cfg_gain_i;
      thr_q    <= cfg_thresh_i;
      bypass_q <= cfg_bypass_i;
      wide_q   <= cfg_wide_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else         v_q <= {v_q[STAGES-2:0], valid_i};
  end

  ddc_nco #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .LUT_W(LUT_W)) nco_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cfg_load_i),
    .freq_i (freq_q),
    .cos_o  (lo_cos),
    .nsin_o (lo_nsin)
  );

  ddc_mix #(.IN_W(IN_W), .LUT_W(LUT_W), .PROD_W(PROD_W)) mix_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .cos_i    (lo_cos),
    .nsin_i   (lo_nsin),
    .bypass_i (bypass_q),
    .prod_i_o (prod[0]),
    .prod_q_o (prod[1])
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    ddc_scale #(.PROD_W(PROD_W), .GAIN_W(GAIN_W), .SHIFT(SHIFT), .SAT_W(SAT_W)) scale_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .prod_i (prod[ch]),
      .gain_i (gain_q),
      .data_o (scl[ch])
    );

    ddc_quant #(.SAT_W(SAT_W), .OUT_W(OUT_W)) quant_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .data_i (scl[ch]),
      .thr_i  (thr_q),
      .wide_i (wide_q),
      .code_o (code[ch])
    );
  end

  assign valid_o = v_q[STAGES-1];
  assign i_o     = code[0];
  assign q_o     = code[1];

  a_r2_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> $stable(freq_q) && $stable(gain_q) && $stable(thr_q)
                    && $stable(bypass_q) && $stable(wide_q));

  a_r11_valid_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##3 valid_o);

  a_r11_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##3 !valid_o);

endmodule

// File: tb/ddc_requant_tb_top.sv
module ddc_requant_tb_top;

  localparam real PI = 3.14159265358979;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  sample_i = '0;
  logic        cfg_load_i = 1'b0;
  logic [31:0] cfg_freq_i = '0;
  logic [7:0]  cfg_gain_i = '0;
  logic [6:0]  cfg_thresh_i = '0;
  logic        cfg_bypass_i = 1'b0;
  logic        cfg_wide_i = 1'b0;
  logic        valid_o;
  logic [3:0]  i_o;
  logic [3:0]  q_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_freq = '0;
  int          m_gain = 64;
  int          m_thr = 32;
  bit          m_bypass = 1'b0;
  bit          m_wide = 1'b0;
  logic [31:0] m_acc = '0;
  string       cur_tag = "R1";
  bit          last_vo;
  logic [7:0]  exp_q[$];

  ddc_requant dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .sample_i     (sample_i),
    .cfg_load_i   (cfg_load_i),
    .cfg_freq_i   (cfg_freq_i),
    .cfg_gain_i   (cfg_gain_i),
    .cfg_thresh_i (cfg_thresh_i),
    .cfg_bypass_i (cfg_bypass_i),
    .cfg_wide_i   (cfg_wide_i),
    .valid_o      (valid_o),
    .i_o          (i_o),
    .q_o          (q_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic int rnd(real x);
    if (x >= 0.0) return int'($floor(x + 0.5));
    return -int'($floor(-x + 0.5));
  endfunction

  function automatic int scale_sat(int p);
    int s;
    s = (p * m_gain) >>> 6;
    if (s > 127)  s = 127;
    if (s < -128) s = -128;
    return s;
  endfunction

  function automatic logic [3:0] quant(int s);
    if (m_wide)      return 4'(s >>> 4);
    if (s >= m_thr)  return 4'd3;
    if (s >= 0)      return 4'd2;
    if (s >= -m_thr) return 4'd1;
    return 4'd0;
  endfunction

  function automatic logic [7:0] ref_out(logic [2:0] code, logic [31:0] ph);
    int  lvl;
    int  k;
    int  cv;
    int  sv;
    int  pi_v;
    int  pq_v;
    real ang;
    lvl = 2 * int'(code) - 7;
    k   = int'(ph[31:26]);
    ang = 2.0 * PI * real'(k) / 64.0;
    cv  = rnd(31.0 * $cos(ang));
    sv  = -rnd(31.0 * $sin(ang));
    if (m_bypass) begin
      pi_v = lvl * 31;
      pq_v = 0;
    end else begin
      pi_v = lvl * cv;
      pq_v = lvl * sv;
    end
    return {quant(scale_sat(pi_v)), quant(scale_sat(pq_v))};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    logic [7:0] e;
    last_vo = valid_o;
    if (valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected valid_o", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check({i_o, q_o} == e, cur_tag, int'({i_o, q_o}), int'(e));
      end
    end
  endtask

  // one clock: check outputs, drive inputs, noise on config pins (R2)
  task automatic tick(bit v, logic [2:0] code);
    @(negedge clk_i);
    check_out();
    valid_i      = v;
    sample_i     = code;
    cfg_load_i   = 1'b0;
    cfg_freq_i   = $urandom;
    cfg_gain_i   = 8'($urandom);
    cfg_thresh_i = 7'($urandom);
    cfg_bypass_i = 1'($urandom);
    cfg_wide_i   = 1'($urandom);
    if (v) exp_q.push_back(ref_out(code, m_acc));
    m_acc = m_acc + m_freq;
  endtask

  task automatic load_cfg(logic [31:0] f, int g, int t, bit b, bit w);
    @(negedge clk_i);
    check_out();
    valid_i      = 1'b0;
    cfg_load_i   = 1'b1;
    cfg_freq_i   = f;
    cfg_gain_i   = 8'(g);
    cfg_thresh_i = 7'(t);
    cfg_bypass_i = b;
    cfg_wide_i   = w;
    m_freq = f; m_gain = g; m_thr = t; m_bypass = b; m_wide = w;
    m_acc  = '0;
  endtask

  task automatic drain();
    repeat (5) tick(1'b0, 3'd0);
    check(exp_q.size() == 0, "R11 missing outputs", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(valid_o == 1'b0, "R1 valid_o in reset", int'(valid_o), 0);
    check({i_o, q_o} == 8'h00, "R1 outputs in reset", int'({i_o, q_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o == 1'b0, "R1 valid_o after reset", int'(valid_o), 0);

    // R1, R4, R8: default configuration, all codes, no load
    cur_tag = "R1 default config";
    for (int c = 0; c < 8; c++) tick(1'b1, 3'(c));
    drain();

    // R4, R6: level mapping through unity-phase LO, 4-bit out
    load_cfg(32'd0, 16, 32, 1'b0, 1'b1);
    cur_tag = "R4 level map";
    for (int c = 0; c < 8; c++) tick(1'b1, 3'(c));
    drain();

    // R5: step one table entry per clock over a full period
    load_cfg(32'h0400_0000, 16, 32, 1'b0, 1'b1);
    cur_tag = "R5 table sweep";
    for (int n = 0; n < 64; n++) tick(1'b1, 3'd7);
    drain();
    // R3: reload restarts phase at 0, idle cycles still advance phase
    load_cfg(32'h0400_0000, 16, 32, 1'b0, 1'b1);
    cur_tag = "R3 phase restart";
    for (int n = 0; n < 16; n++) tick(n % 3 == 0, 3'd1);
    drain();

    // R7: saturation and zero gain
    load_cfg(32'd0, 255, 32, 1'b0, 1'b1);
    cur_tag = "R7 saturation";
    tick(1'b1, 3'd7); tick(1'b1, 3'd0); tick(1'b1, 3'd4);
    drain();
    load_cfg(32'd0, 0, 32, 1'b0, 1'b1);
    cur_tag = "R7 zero gain";
    tick(1'b1, 3'd7); tick(1'b1, 3'd0);
    drain();

    // R8: threshold extremes
    load_cfg(32'h1000_0000, 64, 0, 1'b0, 1'b0);
    cur_tag = "R8 threshold 0";
    for (int c = 0; c < 8; c++) tick(1'b1, 3'(c));
    drain();
    load_cfg(32'h1000_0000, 64, 127, 1'b0, 1'b0);
    cur_tag = "R8 threshold 127";
    for (int c = 0; c < 8; c++) tick(1'b1, 3'(c));
    drain();

    // R10: bypass ignores LO phase
    load_cfg(32'h0C00_0000, 40, 20, 1'b1, 1'b1);
    cur_tag = "R10 bypass";
    for (int n = 0; n < 16; n++) tick(1'b1, 3'(n));
    drain();

    // R2: config pins toggle every cycle without load
    load_cfg(32'h0800_0000, 48, 24, 1'b0, 1'b0);
    cur_tag = "R2 no load";
    for (int n = 0; n < 32; n++) tick(1'b1, 3'($urandom));
    drain();

    // R11: latency of exactly three clocks
    cur_tag = "R11 latency";
    tick(1'b1, 3'd5);
    tick(1'b0, 3'd0);
    check(last_vo == 1'b0, "R11 early valid (1)", int'(last_vo), 0);
    tick(1'b0, 3'd0);
    check(last_vo == 1'b0, "R11 early valid (2)", int'(last_vo), 0);
    tick(1'b0, 3'd0);
    check(last_vo == 1'b1, "R11 valid at 3", int'(last_vo), 1);
    drain();

    // random configurations and sample streams
    for (int it = 0; it < 24; it++) begin
      load_cfg((it % 3 == 0) ? 32'($urandom % 32'h0200_0000) : $urandom,
               (it % 5 == 0) ? 255 : int'($urandom % 256),
               int'($urandom % 128), it % 4 == 1, 1'($urandom));
      cur_tag = m_bypass ? "R10 random" : (m_wide ? "R9 random" : "R8 random");
      for (int n = 0; n < 60; n++) tick(($urandom % 4) != 0, 3'($urandom));
      drain();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule